// File: doc/BRIEF.md
# Display Capability Section Stream Parser

This block takes a display capability section one byte per cycle on a valid/ready stream. It checks the four-byte section header, then walks the variable-length data blocks that fill the data area. For every block that fits, it emits one header beat carrying the tag, the three-bit revision and the payload length. The payload bytes follow as data beats, with flags on the first and last byte. A block's payload is passed on as it is and never interpreted.

The data area length comes from header byte 1, so the parser always knows where a section ends. The section closes with a checksum byte at offset N+4, where N is the data area length. When the section ends, the parser gives a one-cycle completion pulse and a result code. It then waits for the next section's first byte. Blocks are read back to back, starting at offset 4. A remainder of fewer than three bytes cannot hold a block header, so it is treated as zero padding.

A downstream stall holds the current output beat and stops input acceptance. No input byte is lost or duplicated.

Top module: `capsec_parser`

## Requirements
- R1: After synchronous reset, `in_ready` is 1 and `out_valid`, `sec_done` and `sec_err` are 0.
- R2: Each block is read from three header bytes: tag, revision byte and payload length. When that length fits in the remaining area, the parser emits one beat with `out_is_hdr`=1. That beat carries `out_tag`, `out_rev` (bits 2:0 of the revision byte) and `out_len`, with `out_data`, `out_first` and `out_last` all zero.
- R3: Each payload byte leaves in order as one beat with `out_is_hdr`=0 and the byte in `out_data`. `out_first` is set on the first payload byte and `out_last` on the last, and `out_tag`, `out_rev` and `out_len` are zero. A block of length 0 gives only its header beat.
- R4: The checksum passes when the 8-bit sum of all section bytes, checksum byte included, is zero. That gives result code 0. Otherwise the result code is 5 (checksum).
- R5: A first byte other than 0x20 gives code 1 (version). The section then ends after its four header bytes.
- R6: A length byte above 251 gives code 2 (length), and the section ends after its four header bytes. A version error takes priority over a length error.
- R7: A block whose payload length exceeds the area bytes left after its header gives code 3 (overrun). That block and everything after it produce no beats. The section still ends at the checksum byte at offset N+4.
- R8: When one or two area bytes remain where a block header would start, those bytes are padding. A nonzero padding byte gives code 4 (padding).
- R9: The first error detected sets the code. Later errors and the checksum leave it unchanged. `sec_err` shows the code from the cycle after detection until the next section's first byte is accepted, and it changes only when an input byte is accepted.
- R10: While `out_valid` is 1 and `out_ready` is 0, every output beat field stays stable and `in_ready` is 0.
- R11: `sec_done` is a one-cycle pulse in the cycle after the section's final byte is accepted. The next byte accepted is the first byte of a new section.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Parser can take a byte |
| in_data | input | 8 | Section byte |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the beat |
| out_is_hdr | output | 1 | 1 = block header beat, 0 = payload beat |
| out_tag | output | 8 | Block tag (header beat) |
| out_rev | output | 3 | Block revision (header beat) |
| out_len | output | 8 | Payload length (header beat) |
| out_data | output | 8 | Payload byte (payload beat) |
| out_first | output | 1 | First payload byte of a block |
| out_last | output | 1 | Last payload byte of a block |
| sec_done | output | 1 | Section finished (one-cycle pulse) |
| sec_err | output | 3 | Result code: 0 ok, 1 version, 2 length, 3 overrun, 4 padding, 5 checksum |

## Verification
Some rules are checked by the bound properties on every cycle. These are the stall rules: a held beat stays stable and input is blocked. The completion pulse lasts one cycle, the first/last flags appear only on payload beats, and the result code changes only when a byte is accepted.

Other behaviour shows only in whole-section scenarios that the bench compares against its own walk of the byte list. That covers which blocks produce beats and their contents. It also covers where a section ends after each kind of error, which error wins when several occur, the padding rule, and the checksum verdict.

// File: rtl/capsec_pkg.sv
`timescale 1ns/1ps
package capsec_pkg;
    localparam int BYTE_W = 8;
    localparam int REV_W  = 3;
    localparam int ERR_W  = 3;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t BLK_HDR = 8'd3;

    typedef enum logic [ERR_W-1:0] {
        ERR_NONE     = 3'd0,
        ERR_VERSION  = 3'd1,
        ERR_LENGTH   = 3'd2,
        ERR_OVERRUN  = 3'd3,
        ERR_PADDING  = 3'd4,
        ERR_CHECKSUM = 3'd5
    } err_e;

    typedef enum logic [3:0] {
        PS_VER, PS_LEN, PS_USE, PS_EXT,
        PS_TAG, PS_REV, PS_PLEN, PS_PAY,
        PS_PAD, PS_SKIP, PS_SUM
    } pstate_e;

    typedef struct packed {
        logic             is_hdr;
        byte_t            tag;
        logic [REV_W-1:0] rev;
        byte_t            len;
        byte_t            data;
        logic             first;
        logic             last;
    } beat_t;

    // Where to go once a block (or the header) is done, given area bytes left
    function automatic pstate_e route_next(byte_t left);
        if (left == '0)
            return PS_SUM;
        else if (left < BLK_HDR)
            return PS_PAD;
        else
            return PS_TAG;
    endfunction
endpackage

// File: rtl/capsec_cksum.sv
`timescale 1ns/1ps
module capsec_cksum
    import capsec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fire,
    input  logic  start,
    input  byte_t din,
    output byte_t sum_o
);
    byte_t sum_q;

    always_ff @(posedge clk) begin
        if (rst)
            sum_q <= '0;
        else if (fire)
            sum_q <= start ? din : byte_t'(sum_q + din);
    end

    assign sum_o = sum_q;
endmodule

// File: rtl/capsec_outq.sv
`timescale 1ns/1ps
module capsec_outq
    import capsec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  beat_t beat_in,
    input  logic  out_ready,
    output logic  out_valid,
    output beat_t beat_o
);
    logic  vld_q;
    beat_t beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            beat_q <= '0;
        end else if (load) begin
            vld_q  <= 1'b1;
            beat_q <= beat_in;
        end else if (out_ready) begin
            vld_q  <= 1'b0;
        end
    end

    assign out_valid = vld_q;
    assign beat_o    = beat_q;
endmodule

// File: rtl/capsec_walk.sv
`timescale 1ns/1ps
module capsec_walk
    import capsec_pkg::*;
#(
    parameter byte_t VERSION_ID = 8'h20,
    parameter byte_t MAX_AREA   = 8'd251
)(
    input  logic  clk,
    input  logic  rst,
    input  logic  fire,
    input  byte_t din,
    input  byte_t sum_cur,
    output logic  start_o,
    output logic  emit_o,
    output beat_t beat_o,
    output logic  done_o,
    output err_e  err_o
);
    pstate_e          st_q, st_d;
    byte_t            area_q, area_d;
    byte_t            blk_q, blk_d;
    byte_t            plen_q, plen_d;
    byte_t            tag_q, tag_d;
    logic [REV_W-1:0] rev_q, rev_d;
    err_e             err_q, err_d;
    logic             done_q, done_d;
    byte_t            area_dec;
    byte_t            sum_fin;

    assign area_dec = area_q - 8'd1;
    assign sum_fin  = sum_cur + din;
    assign start_o  = fire && (st_q == PS_VER);

    always_comb begin
        st_d   = st_q;
        area_d = area_q;
        blk_d  = blk_q;
        plen_d = plen_q;
        tag_d  = tag_q;
        rev_d  = rev_q;
        err_d  = err_q;
        done_d = 1'b0;
        emit_o = 1'b0;
        beat_o = '0;
        if (fire) begin
            unique case (st_q)
                PS_VER: begin
                    err_d = (din != VERSION_ID) ? ERR_VERSION : ERR_NONE;
                    st_d  = PS_LEN;
                end
                PS_LEN: begin
                    area_d = din;
                    if (err_q == ERR_NONE && din > MAX_AREA)
                        err_d = ERR_LENGTH;
                    st_d = PS_USE;
                end
                PS_USE: st_d = PS_EXT;
                PS_EXT: begin
                    if (err_q != ERR_NONE) begin
                        done_d = 1'b1;
                        st_d   = PS_VER;
                    end else begin
                        st_d = route_next(area_q);
                    end
                end
                PS_TAG: begin
                    tag_d  = din;
                    area_d = area_dec;
                    st_d   = PS_REV;
                end
                PS_REV: begin
                    rev_d  = din[REV_W-1:0];
                    area_d = area_dec;
                    st_d   = PS_PLEN;
                end
                PS_PLEN: begin
                    area_d = area_dec;
                    if (din > area_dec) begin
                        err_d = ERR_OVERRUN;
                        st_d  = (area_dec == '0) ? PS_SUM : PS_SKIP;
                    end else begin
                        emit_o        = 1'b1;
                        beat_o.is_hdr = 1'b1;
                        beat_o.tag    = tag_q;
                        beat_o.rev    = rev_q;
                        beat_o.len    = din;
                        plen_d        = din;
                        blk_d         = din;
                        st_d          = (din == '0) ? route_next(area_dec) : PS_PAY;
                    end
                end
                PS_PAY: begin
                    emit_o       = 1'b1;
                    beat_o.data  = din;
                    beat_o.first = (blk_q == plen_q);
                    beat_o.last  = (blk_q == 8'd1);
                    area_d       = area_dec;
                    blk_d        = blk_q - 8'd1;
                    if (blk_q == 8'd1)
                        st_d = route_next(area_dec);
                end
                PS_PAD: begin
                    if (din != '0 && err_q == ERR_NONE)
                        err_d = ERR_PADDING;
                    area_d = area_dec;
                    if (area_dec == '0)
                        st_d = PS_SUM;
                end
                PS_SKIP: begin
                    area_d = area_dec;
                    if (area_dec == '0)
                        st_d = PS_SUM;
                end
                PS_SUM: begin
                    done_d = 1'b1;
                    st_d   = PS_VER;
                    if (err_q == ERR_NONE && sum_fin != '0)
                        err_d = ERR_CHECKSUM;
                end
                default: st_d = PS_VER;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PS_VER;
            area_q <= '0;
            blk_q  <= '0;
            plen_q <= '0;
            tag_q  <= '0;
            rev_q  <= '0;
            err_q  <= ERR_NONE;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            area_q <= area_d;
            blk_q  <= blk_d;
            plen_q <= plen_d;
            tag_q  <= tag_d;
            rev_q  <= rev_d;
            err_q  <= err_d;
            done_q <= done_d;
        end
    end

    assign done_o = done_q;
    assign err_o  = err_q;
endmodule

// File: rtl/capsec_parser.sv
`timescale 1ns/1ps
module capsec_parser
    import capsec_pkg::*;
#(
    parameter byte_t VERSION_ID = 8'h20,
    parameter byte_t MAX_AREA   = 8'd251
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_is_hdr,
    output logic [7:0] out_tag,
    output logic [2:0] out_rev,
    output logic [7:0] out_len,
    output logic [7:0] out_data,
    output logic       out_first,
    output logic       out_last,
    output logic       sec_done,
    output logic [2:0] sec_err
);
    logic  fire;
    logic  start_w;
    logic  emit_w;
    beat_t beat_w;
    beat_t beat_q;
    byte_t sum_w;
    err_e  err_w;

    assign in_ready = !(out_valid && !out_ready);
    assign fire     = in_valid && in_ready;

    capsec_cksum u_cksum (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .start (start_w),
        .din   (in_data),
        .sum_o (sum_w)
    );

    capsec_walk #(
        .VERSION_ID (VERSION_ID),
        .MAX_AREA   (MAX_AREA)
    ) u_walk (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .din     (in_data),
        .sum_cur (sum_w),
        .start_o (start_w),
        .emit_o  (emit_w),
        .beat_o  (beat_w),
        .done_o  (sec_done),
        .err_o   (err_w)
    );

    capsec_outq u_outq (
        .clk       (clk),
        .rst       (rst),
        .load      (emit_w),
        .beat_in   (beat_w),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .beat_o    (beat_q)
    );

    assign out_is_hdr = beat_q.is_hdr;
    assign out_tag    = beat_q.tag;
    assign out_rev    = beat_q.rev;
    assign out_len    = beat_q.len;
    assign out_data   = beat_q.data;
    assign out_first  = beat_q.first;
    assign out_last   = beat_q.last;
    assign sec_err    = err_w;
endmodule

// File: rtl/capsec_parser_chk.sv
`timescale 1ns/1ps
module capsec_parser_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] in_data,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_is_hdr,
    input logic [7:0] out_tag,
    input logic [2:0] out_rev,
    input logic [7:0] out_len,
    input logic [7:0] out_data,
    input logic       out_first,
    input logic       out_last,
    input logic       sec_done,
    input logic [2:0] sec_err
);
    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid &&
        $stable({out_is_hdr, out_tag, out_rev, out_len, out_data, out_first, out_last}));

    // R10
    stall_block_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sec_done |=> !sec_done);

    // R3
    flag_on_payload_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && (out_first || out_last) |-> !out_is_hdr);

    // R9
    err_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> $stable(sec_err));
endmodule

bind capsec_parser capsec_parser_chk u_chk (.*);

// File: tb/capsec_parser_bench.sv
`timescale 1ns/1ps
module capsec_parser_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic       in_ready;
    logic [7:0] in_data;
    logic       out_valid;
    logic       out_ready;
    logic       out_is_hdr;
    logic [7:0] out_tag;
    logic [2:0] out_rev;
    logic [7:0] out_len;
    logic [7:0] out_data;
    logic       out_first;
    logic       out_last;
    logic       sec_done;
    logic [2:0] sec_err;

    always #5 clk = ~clk;

    capsec_parser u_capsec_parser (.*);

    logic [7:0]  sec[$];
    logic [29:0] exp_q[$];
    logic [29:0] cap_q[$];
    int          done_cnt = 0;
    logic        hold = 1'b0;
    int          ready_pct = 100;
    int          n_chk = 0;
    int          n_bad = 0;

    function automatic logic [29:0] pack(input logic h, input logic [7:0] t, input logic [2:0] r,
                                         input logic [7:0] l, input logic [7:0] d,
                                         input logic f, input logic la);
        return {h, t, r, l, d, f, la};
    endfunction

    function automatic logic [29:0] snap();
        return {out_is_hdr, out_tag, out_rev, out_len, out_data, out_first, out_last};
    endfunction

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'd1:    return "R5";
            3'd2:    return "R6";
            3'd3:    return "R7";
            3'd4:    return "R8";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // downstream consumer and event monitor
    always @(negedge clk) begin
        out_ready = hold ? 1'b0 : (($urandom % 100) < ready_pct);
        if (!rst && out_valid && out_ready) cap_q.push_back(snap());
        if (!rst && sec_done) done_cnt++;
    end

    task automatic send(input logic [7:0] b);
        forever begin
            @(negedge clk);
            #1;
            in_valid = 1'b1;
            in_data  = b;
            if (in_ready) begin
                @(posedge clk);
                break;
            end
        end
    endtask

    // reference walk of the section from the requirements
    task automatic model_run(output logic [2:0] code, output int nb);
        logic [7:0] sum;
        int n, p, e, len;
        exp_q.delete();
        code = 3'd0;
        if (sec[0] != 8'h20) code = 3'd1;
        else if (sec[1] > 8'd251) code = 3'd2;
        if (code != 3'd0) begin
            nb = 4;
            return;
        end
        n = int'(sec[1]);
        nb = n + 5;
        e = 4 + n;
        p = 4;
        sum = 8'd0;
        for (int i = 0; i < nb; i++) sum = sum + sec[i];
        while (p < e && code == 3'd0) begin
            if (e - p < 3) begin
                for (int i = p; i < e; i++) if (sec[i] != 8'd0) code = 3'd4;
                p = e;
            end else begin
                len = int'(sec[p+2]);
                if (len > e - p - 3) begin
                    code = 3'd3;
                end else begin
                    exp_q.push_back(pack(1'b1, sec[p], sec[p+1][2:0], sec[p+2], 8'd0, 1'b0, 1'b0));
                    for (int i = 0; i < len; i++)
                        exp_q.push_back(pack(1'b0, 8'd0, 3'd0, 8'd0, sec[p+3+i], i == 0, i == len - 1));
                end
                p = p + 3 + len;
            end
        end
        if (code == 3'd0 && sum != 8'd0) code = 3'd5;
    endtask

    task automatic run_section(input string req);
        logic [2:0] code;
        int nb, bad_idx;
        model_run(code, nb);
        cap_q.delete();
        done_cnt = 0;
        for (int i = 0; i < nb; i++) send(sec[i]);
        @(negedge clk);
        #1;
        in_valid = 1'b0;
        chk(sec_done == 1'b1, "R11", "done pulse after final byte", 32'(sec_done), 32'd1);
        chk(sec_err == code, req_of(code), {req, " result code"}, 32'(sec_err), 32'(code));
        for (int w = 0; w < 600 && cap_q.size() < exp_q.size(); w++) @(negedge clk);
        repeat (3) @(negedge clk);
        #1;
        chk(done_cnt == 1, "R11", "done pulses per section", 32'(done_cnt), 32'd1);
        chk(cap_q.size() == exp_q.size(), "R3", "beat count", 32'(cap_q.size()), 32'(exp_q.size()));
        bad_idx = -1;
        for (int i = 0; i < exp_q.size() && i < cap_q.size(); i++)
            if (bad_idx < 0 && cap_q[i] != exp_q[i]) bad_idx = i;
        if (bad_idx >= 0)
            chk(1'b0, "R2", "beat content", 32'(cap_q[bad_idx]), 32'(exp_q[bad_idx]));
        else
            chk(1'b1, "R2", "beat content", 32'd0, 32'd0);
        chk(sec_err == code, "R9", "code held after end", 32'(sec_err), 32'(code));
    endtask

    task automatic open_sec(input logic [7:0] v, input logic [7:0] n);
        sec.delete();
        sec.push_back(v);
        sec.push_back(n);
        sec.push_back(8'd2);
        sec.push_back(8'd0);
    endtask

    task automatic add(input logic [7:0] b);
        sec.push_back(b);
    endtask

    task automatic close_sum();
        logic [7:0] s;
        s = 8'd0;
        foreach (sec[i]) s = s + sec[i];
        sec.push_back(8'd0 - s);
    endtask

    task automatic rand_section();
        int n, left, mx, l, mode;
        n = $urandom % 48;
        open_sec(8'h20, 8'(n));
        left = n;
        while (left >= 3) begin
            mx = left - 3;
            if (mx > 12) mx = 12;
            l = $urandom % (mx + 1);
            add(($urandom % 4 == 0) ? 8'h7E : 8'(8'h20 + $urandom % 10));
            add(8'($urandom));
            add(8'(l));
            for (int i = 0; i < l; i++) add(8'($urandom));
            left = left - 3 - l;
        end
        for (int i = 0; i < left; i++) add(8'd0);
        close_sum();
        mode = $urandom % 10;
        case (mode)
            0: sec[sec.size()-1] = sec[sec.size()-1] ^ 8'h01;
            1: sec[0] = 8'h21;
            2: sec[1] = 8'(252 + $urandom % 4);
            3: if (n >= 3) sec[6] = 8'hFF;
            4: if (n > 0) sec[4 + $urandom % n] ^= 8'(1 + $urandom % 255);
            default: ;
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        logic [29:0] held;
        void'($urandom(32'd4711));
        rst      = 1'b1;
        in_valid = 1'b0;
        in_data  = 8'd0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'd1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'd0);
        chk(sec_done == 1'b0, "R1", "sec_done after reset", 32'(sec_done), 32'd0);
        chk(sec_err == 3'd0, "R1", "sec_err after reset", 32'(sec_err), 32'd0);

        // R4: empty data area, good checksum
        open_sec(8'h20, 8'd0); close_sum(); run_section("R4 empty area");
        // R2/R3: zero-length block, revision upper bits ignored
        open_sec(8'h20, 8'd3); add(8'h29); add(8'hFD); add(8'd0); close_sum(); run_section("R3 zero length");
        // R3: block exactly filling the area
        open_sec(8'h20, 8'd9); add(8'h22); add(8'h01); add(8'd6);
        for (int i = 0; i < 6; i++) add(8'(8'h10 + i));
        close_sum(); run_section("R3 exact fill");
        // R8: two zero padding bytes pass
        open_sec(8'h20, 8'd5); add(8'h20); add(8'h00); add(8'd0); add(8'd0); add(8'd0);
        close_sum(); run_section("R8 zero pad");
        // R8: nonzero padding
        open_sec(8'h20, 8'd4); add(8'h21); add(8'h00); add(8'd0); add(8'h01);
        close_sum(); run_section("R8 nonzero pad");
        // R5: bad version
        open_sec(8'h12, 8'd3); run_section("R5 version");
        // R6: length 252
        open_sec(8'h20, 8'd252); run_section("R6 length");
        // R6: version error wins over length error
        open_sec(8'h00, 8'd255); run_section("R6 priority");
        // R7 and R9: overrun plus wrong checksum keeps code 3
        open_sec(8'h20, 8'd6); add(8'h24); add(8'h00); add(8'd4); add(8'd1); add(8'd2); add(8'd3);
        add(8'h55); run_section("R7 overrun");
        // R4: wrong checksum
        open_sec(8'h20, 8'd4); add(8'h7E); add(8'h00); add(8'd1); add(8'hAB);
        close_sum(); sec[sec.size()-1] = sec[sec.size()-1] + 8'd1; run_section("R4 bad sum");

        // R10: downstream stall holds the beat and blocks input
        hold = 1'b1;
        open_sec(8'h20, 8'd7); add(8'h23); add(8'h00); add(8'd4);
        add(8'hA1); add(8'hA2); add(8'hA3); add(8'hA4); close_sum();
        fork
            run_section("R10 stall");
            begin
                for (int w = 0; w < 100 && !out_valid; w++) @(negedge clk);
                #2;
                held = snap();
                repeat (5) @(negedge clk);
                #2;
                chk(out_valid == 1'b1, "R10", "beat kept valid", 32'(out_valid), 32'd1);
                chk(in_ready == 1'b0, "R10", "input blocked", 32'(in_ready), 32'd0);
                chk(snap() == held, "R10", "beat stable", 32'(snap()), 32'(held));
                hold = 1'b0;
            end
        join

        // mixed random sections under random backpressure
        for (int s = 0; s < 300; s++) begin
            ready_pct = 30 + $urandom % 71;
            rand_section();
            run_section("random");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule